// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block watches one bank of already-synchronized GPIO input levels and turns selected activity on each pin into a sticky status bit. Three per-pin configuration registers choose the trigger: a kind bit (edge or level), a polarity bit, and a both-edges bit. Together they give five trigger modes: rising edge, falling edge, either edge, active high and active low. Events are found by comparing each pin's level in the current cycle with its level in the previous cycle. Detected events are held in a status register until software acknowledges them by writing ones to that register.

An enable mask decides which status bits reach the single interrupt request line. The mask can only be changed through two write-only addresses. One sets enable bits where the written data has ones. The other clears enable bits where the written data has ones. The mask state can be read back at a third address.

Software reaches the block through a simple write port (strobe, address, data) and a separate combinational read port (address, data).

Top module: `gpio_irq_detect`

## Requirements
- R1: During and directly after reset, all three configuration registers, the status register and the enable mask read 0, and `irq_o` is 0.
- R2: Addresses 0 (kind: 1 = edge, 0 = level), 1 (polarity) and 2 (both-edges) are read/write. A write takes effect on the next clock edge and reads back unchanged.
- R3: With kind=1, both-edges=0 and polarity=1, a pin's status bit sets when the pin was 0 in the previous cycle and is 1 now.
- R4: With kind=1, both-edges=0 and polarity=0, a pin's status bit sets when the pin was 1 in the previous cycle and is 0 now.
- R5: With kind=1 and both-edges=1, a pin's status bit sets on any change of the pin, whatever its polarity bit.
- R6: With kind=0, the status bit sets in every cycle in which the pin equals its polarity bit, whatever its both-edges bit. A bit that is cleared while the level is still active is set again at the next clock edge.
- R7: Status is read at address 3. Writing a 1 to a bit there clears it and writing a 0 leaves it unchanged. If an event and a clear reach the same bit in the same cycle, the bit ends up set.
- R8: Writing to address 4 sets every enable bit where the data has a 1. Bits written with 0 are left unchanged.
- R9: Writing to address 5 clears every enable bit where the data has a 1. Bits written with 0 are left unchanged. The enable mask reads back at address 6. Addresses 4, 5 and 7 read as 0.
- R10: `irq_o` is 1 exactly when at least one pin has both its status bit and its enable bit set.
- R11: The status bit for an event seen on the pin inputs before a clock edge is visible on the read port right after that edge. Configuration written at an edge governs detection from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | NUM_PINS | Write data, one bit per pin |
| rd_addr | input | 3 | Read address |
| rd_data | output | NUM_PINS | Read data for `rd_addr` (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_PINS set to 8. This narrow bank lets every one of the five trigger modes be driven through 256 pin patterns, so each pin meets all four previous/current level pairs under every mode. A cycle-accurate arithmetic model of status, enable and configuration is compared with the read port and `irq_o` after every clock edge. A final phase uses mixed per-pin modes with random writes to every address. This phase reaches the same-cycle clear-versus-event conflict and set/clear sequences on the enable mask.

// File: rtl/gpio_irq_pkg.sv
// Package: shared address width and register selector codes for the
// GPIO interrupt detector. Assumes a 3-bit register address space.
package gpio_irq_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_KIND    = 3'd0,
        SEL_POL     = 3'd1,
        SEL_BOTH    = 3'd2,
        SEL_STATUS  = 3'd3,
        SEL_EN_SET  = 3'd4,
        SEL_EN_CLR  = 3'd5,
        SEL_EN_VIEW = 3'd6
    } reg_sel_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
// Module: configuration and enable-mask storage.
// Holds the kind, polarity and both-edges registers, which are plainly
// writable. It also holds the enable mask, which changes only through the
// set and clear addresses. Assumes one write per cycle.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    output logic [NUM_PINS-1:0] kind_q,
    output logic [NUM_PINS-1:0] pol_q,
    output logic [NUM_PINS-1:0] both_q,
    output logic [NUM_PINS-1:0] en_q
);
    // Store the plain configuration registers on their own addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == SEL_KIND) kind_q <= wr_data;
            if (wr_addr == SEL_POL)  pol_q  <= wr_data;
            if (wr_addr == SEL_BOTH) both_q <= wr_data;
        end
    end

    // Update the enable mask through its set-only and clear-only addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == SEL_EN_SET) en_q <= en_q | wr_data;
            if (wr_addr == SEL_EN_CLR) en_q <= en_q & ~wr_data;
        end
    end
endmodule

// File: rtl/gpio_irq_trig.sv
// Module: per-pin trigger detection.
// Keeps each pin's level from the previous cycle and decides, pin by pin,
// whether the configured trigger condition holds in this cycle. Assumes
// pin_i is already synchronized to clk.
module gpio_irq_trig #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] kind_i,
    input  logic [NUM_PINS-1:0] pol_i,
    input  logic [NUM_PINS-1:0] both_i,
    output logic [NUM_PINS-1:0] evt_o
);
    logic [NUM_PINS-1:0] prev_q;

    // Remember the previous pin levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pin_i;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;
        // Decide this pin's event from its mode bits and level history.
        always_comb begin
            rise      = pin_i[g] & ~prev_q[g];
            fall      = ~pin_i[g] & prev_q[g];
            edge_hit  = both_i[g] ? (rise | fall) : (pol_i[g] ? rise : fall);
            level_hit = pol_i[g] ? pin_i[g] : ~pin_i[g];
            evt_o[g]  = kind_i[g] ? edge_hit : level_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_stat.sv
// Module: sticky status and interrupt combine.
// Status bits set on events and clear on acknowledge. When both reach a bit
// in one cycle, the event wins. The request line is the OR of enabled
// pending bits.
module gpio_irq_stat #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt_i,
    input  logic [NUM_PINS-1:0] ack_i,
    input  logic [NUM_PINS-1:0] en_i,
    output logic [NUM_PINS-1:0] status_q,
    output logic                irq_o
);
    // Latch events and apply acknowledges, with events taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~ack_i) | evt_i;
    end

    // Combine enabled pending bits into one request.
    always_comb begin
        irq_o = |(status_q & en_i);
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: top of the GPIO interrupt detector.
// Wires configuration, trigger detection and status together. It decodes
// the acknowledge write and provides a combinational read mux. Assumes
// synchronized pin levels and a single-cycle write strobe.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    input  logic [2:0]          rd_addr,
    output logic [NUM_PINS-1:0] rd_data,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] kind_q, pol_q, both_q, en_q;
    logic [NUM_PINS-1:0] evt, ack, status_q;

    gpio_irq_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .kind_q(kind_q), .pol_q(pol_q),
        .both_q(both_q), .en_q(en_q)
    );

    gpio_irq_trig #(.NUM_PINS(NUM_PINS)) u_trig (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .kind_i(kind_q),
        .pol_i(pol_q), .both_i(both_q), .evt_o(evt)
    );

    // Decode the acknowledge write into a per-pin clear vector.
    always_comb begin
        ack = (wr_en && wr_addr == SEL_STATUS) ? wr_data : '0;
    end

    gpio_irq_stat #(.NUM_PINS(NUM_PINS)) u_stat (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .ack_i(ack),
        .en_i(en_q), .status_q(status_q), .irq_o(irq_o)
    );

    // Select the register shown on the read port.
    always_comb begin
        case (rd_addr)
            SEL_KIND:    rd_data = kind_q;
            SEL_POL:     rd_data = pol_q;
            SEL_BOTH:    rd_data = both_q;
            SEL_STATUS:  rd_data = status_q;
            SEL_EN_VIEW: rd_data = en_q;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_checker.sv
// Module: temporal checks for the GPIO interrupt detector, bound to the top.
// Assumes the synchronous active-low reset of the design.
module gpio_irq_checker #(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [2:0]          wr_addr,
    input logic [NUM_PINS-1:0] wr_data,
    input logic [NUM_PINS-1:0] evt,
    input logic [NUM_PINS-1:0] status_q,
    input logic [NUM_PINS-1:0] en_q,
    input logic                irq_o
);
    // R11: an event is visible in status after the next edge.
    p_event_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));

    // R7: acknowledged bits without a fresh event are cleared.
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd3) |=>
        ((status_q & $past(wr_data) & ~$past(evt)) == '0));

    // R7: without event or acknowledge, status holds.
    p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0 && !(wr_en && wr_addr == 3'd3)) |=> $stable(status_q));

    // R8: set-write raises every written-one enable bit.
    p_en_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd4) |=> ((en_q & $past(wr_data)) == $past(wr_data)));

    // R9: clear-write drops every written-one enable bit.
    p_en_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd5) |=> ((en_q & $past(wr_data)) == '0));

    // R10: no enabled pending bit means no request.
    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & en_q) == '0) |-> !irq_o);
endmodule

bind gpio_irq_detect gpio_irq_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .evt(evt), .status_q(status_q), .en_q(en_q),
    .irq_o(irq_o)
);

// File: tb/tb_gpio_irq_detect.sv
module tb_gpio_irq_detect;
    localparam int NP = 8;
    localparam logic [NP-1:0] ONES = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_i = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [NP-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [NP-1:0] rd_data;
    logic          irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    // Bench model of the block state.
    logic [NP-1:0] m_kind = '0, m_pol = '0, m_both = '0, m_en = '0;
    logic [NP-1:0] m_stat = '0, m_prev = '0;

    always #2 clk = ~clk;

    gpio_irq_detect #(.NUM_PINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq_o(irq_o)
    );

    function automatic logic [NP-1:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_kind;
            3'd1: return m_pol;
            3'd2: return m_both;
            3'd3: return m_stat;
            3'd6: return m_en;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [NP-1:0] act,
                         input logic [NP-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model, check after the edge.
    task automatic step(input logic [NP-1:0] pins, input logic we,
                        input logic [2:0] wa, input logic [NP-1:0] wd,
                        input logic [2:0] ra, input string tag);
        logic [NP-1:0] rise, fall, edge_v, lvl, ev, ack;
        @(negedge clk);
        pin_i = pins; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        rise   = pins & ~m_prev;
        fall   = ~pins & m_prev;
        edge_v = (m_both & (rise | fall)) | (~m_both & ((m_pol & rise) | (~m_pol & fall)));
        lvl    = (m_pol & pins) | (~m_pol & ~pins);
        ev     = (m_kind & edge_v) | (~m_kind & lvl);
        ack    = (we && wa == 3'd3) ? wd : '0;
        m_stat = (m_stat & ~ack) | ev;
        if (we) begin
            if (wa == 3'd0) m_kind = wd;
            if (wa == 3'd1) m_pol  = wd;
            if (wa == 3'd2) m_both = wd;
            if (wa == 3'd4) m_en   = m_en | wd;
            if (wa == 3'd5) m_en   = m_en & ~wd;
        end
        m_prev = pins;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        check(tag, rd_data, model_read(ra));
        check({tag, " R10 irq"}, {{(NP-1){1'b0}}, irq_o},
              {{(NP-1){1'b0}}, |(m_stat & m_en)});
    endtask

    task automatic set_mode(input logic [NP-1:0] k, input logic [NP-1:0] p,
                            input logic [NP-1:0] b, input string tag);
        step(m_prev, 1'b1, 3'd0, k, 3'd0, {tag, " R2"});
        step(m_prev, 1'b1, 3'd1, p, 3'd1, {tag, " R2"});
        step(m_prev, 1'b1, 3'd2, b, 3'd2, {tag, " R2"});
    endtask

    // Sweep 256 pin patterns under one mode, with acknowledges and mask writes.
    task automatic sweep(input int seed, input string tag);
        for (int i = 0; i < 256; i++) begin
            logic [NP-1:0] pins;
            pins = NP'((i * 73 + seed * 29) ^ (i >> 1));
            if (i % 4 == 1)
                step(pins, 1'b1, 3'd3, NP'(i * 37), 3'd3, tag);
            else if (i % 8 == 2)
                step(pins, 1'b1, 3'd4, NP'(i * 11 + seed), 3'd3, tag);
            else if (i % 8 == 6)
                step(pins, 1'b1, 3'd5, NP'(i * 5), 3'd3, tag);
            else
                step(pins, 1'b0, 3'd0, '0, 3'd3, tag);
        end
    endtask

    initial begin
        // R1: reset state, observed during reset.
        for (int a = 0; a < 8; a++) begin
            @(negedge clk);
            rd_addr = 3'(a);
            #1;
            check("R1 reset read", rd_data, '0);
            check("R1 reset irq", {{(NP-1){1'b0}}, irq_o}, '0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // R1 / R6: directly after reset everything is 0. The default level-low
        // mode then latches low pins at the first edge.
        #1;
        rd_addr = 3'd3;
        #1;
        check("R1 status after reset", rd_data, '0);
        rd_addr = 3'd6;
        #1;
        check("R1 enable after reset", rd_data, '0);
        step('0, 1'b0, 3'd0, '0, 3'd3, "R6 default level-low");

        // R2 / R9: configuration readback and empty addresses.
        set_mode(8'hA5, 8'h3C, 8'h5A, "R2 cfg");
        step(m_prev, 1'b0, 3'd0, '0, 3'd4, "R9 set addr reads 0");
        step(m_prev, 1'b0, 3'd0, '0, 3'd5, "R9 clr addr reads 0");
        step(m_prev, 1'b0, 3'd0, '0, 3'd7, "R9 addr7 reads 0");

        // R3: rising edge.
        set_mode(ONES, ONES, '0, "R3 rise");
        step('0, 1'b1, 3'd3, ONES, 3'd3, "R3 R7 ack");
        sweep(1, "R3 R11 rise sweep");
        // R4: falling edge.
        set_mode(ONES, '0, '0, "R4 fall");
        sweep(2, "R4 R11 fall sweep");
        // R5: both edges, polarity ignored.
        set_mode(ONES, 8'h96, ONES, "R5 both");
        sweep(3, "R5 both sweep");
        // R6: level high and low, both-edges bit ignored.
        set_mode('0, ONES, ONES, "R6 high");
        sweep(4, "R6 level-high sweep");
        set_mode('0, '0, 8'h0F, "R6 low");
        sweep(5, "R6 level-low sweep");

        // R6 / R7: ack during active level loses to the event.
        set_mode('0, ONES, '0, "R7 dir");
        step(ONES, 1'b0, 3'd0, '0, 3'd3, "R6 level set");
        step(ONES, 1'b1, 3'd3, ONES, 3'd3, "R7 event wins over ack");
        step(8'h0F, 1'b1, 3'd3, ONES, 3'd3, "R6 R7 partial re-set");
        check("R6 R7 expect low nibble", rd_data, 8'h0F);
        set_mode(ONES, ONES, '0, "R7 edge");
        step(8'h0F, 1'b1, 3'd3, 8'h00, 3'd3, "R7 write zero keeps");
        step(8'h0F, 1'b1, 3'd3, 8'h03, 3'd3, "R7 partial ack");
        check("R7 partial ack value", rd_data, 8'h0C);
        // R8 / R9 / R10: mask control.
        step(8'h0F, 1'b1, 3'd5, ONES, 3'd6, "R9 clear all");
        step(8'h0F, 1'b1, 3'd4, 8'h00, 3'd6, "R8 zero set no effect");
        step(8'h0F, 1'b1, 3'd4, 8'h04, 3'd6, "R8 R10 set one");
        check("R10 irq from pin2", {{(NP-1){1'b0}}, irq_o}, 8'h01);
        step(8'h0F, 1'b1, 3'd5, 8'h00, 3'd6, "R9 zero clear no effect");
        step(8'h0F, 1'b1, 3'd5, 8'h04, 3'd6, "R9 R10 clear one");
        check("R10 irq off", {{(NP-1){1'b0}}, irq_o}, 8'h00);

        // Mixed per-pin modes with random traffic.
        for (int i = 0; i < 600; i++) begin
            logic [2:0] wa;
            wa = 3'($urandom_range(0, 7));
            step(NP'($urandom), ($urandom_range(0, 2) != 0), wa, NP'($urandom),
                 3'($urandom_range(0, 7)), "R2 R7 R8 R9 R10 mixed");
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule